// File: doc/BRIEF.md
# Debug Mode Entry/Exit Controller

This block tracks whether a processor core is in debug mode and decides when it enters and leaves that mode. It keeps the exception cause register. Each bit of that register is set by a per-source exception event and stays set. The block ANDs the register with a debug enable vector that the core supplies. Any overlap while the core is running starts debug mode.

On entry the block pulses the save strobes for the two save/restore registers. It also pulses a clear for the external interrupt enable bit and captures the program counter and machine state. One cycle later it raises the freeze and debug-mode outputs. While in debug mode, exceptions are only recorded. They set cause bits and drive an OR-of-causes flag to the external tool. They never save state again. Breakpoint and watchpoint requests are suppressed in debug mode. Any attempt to set the external interrupt enable in debug mode is flagged as an illegal write.

A return-from-interrupt strobe leaves debug mode. If an enabled cause is still pending at that point, the block enters debug mode again straight away. The tool clears the cause register by reading it with the read strobe.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, freeze, debugMode, ecrOr, illegalEeWr and causeReg are all zero.
- R2: A one in bit i of causeEvt sets bit i of causeReg on the next cycle, both inside and outside debug mode. The bit stays set until a read clears it.
- R3: When causeReg & dbgEnable is nonzero and the block is not in debug mode, debugMode and freeze go high on the next cycle. Cause bits that are not enabled never start debug mode.
- R4: A cycle with causeRdStrobe high clears causeReg on the next cycle. The exception is bits that causeEvt sets in that same cycle: those bits hold 1.
- R5: In the cycle where entry is decided, saveSrr0, saveSrr1 and eeClear are high for one cycle. On the next cycle, savedPc and savedMsr hold the curPc and curMsr values of that cycle.
- R6: While in debug mode, saveSrr0 and saveSrr1 stay low, and savedPc and savedMsr do not change, whatever exceptions arrive.
- R7: ecrOr equals the OR of all causeReg bits while debugMode is high. It is 0 while debugMode is low.
- R8: bpWpOut equals bpWpReq outside debug mode. It is all zeros in debug mode.
- R9: illegalEeWr is high in the cycle after a cycle in which eeSetReq was high while in debug mode. It is low after an eeSetReq made outside debug mode.
- R10: rfiStrobe in debug mode drops debugMode and freeze on the next cycle. With no enabled cause pending, they stay low.
- R11: If an enabled cause is still pending when rfiStrobe leaves debug mode, the save strobes fire in the following cycle and freeze is high again two cycles after the strobe.
- R12: rfiStrobe outside debug mode has no effect: freeze and debugMode stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| causeEvt | input | CAUSE_W | Per-source exception event pulses |
| dbgEnable | input | CAUSE_W | Debug enable vector, one bit per source |
| rfiStrobe | input | 1 | Return-from-interrupt executed |
| causeRdStrobe | input | 1 | Cause register read (clears it) |
| eeSetReq | input | 1 | Software attempt to set the external interrupt enable |
| bpWpReq | input | BPWP_W | Raw breakpoint/watchpoint requests |
| curPc | input | PC_W | Current program counter |
| curMsr | input | MSR_W | Current machine state |
| freeze | output | 1 | Freeze indication |
| debugMode | output | 1 | Core is in debug mode |
| ecrOr | output | 1 | OR of cause bits, valid in debug mode |
| saveSrr0 | output | 1 | Save strobe for the program counter save register |
| saveSrr1 | output | 1 | Save strobe for the machine state save register |
| eeClear | output | 1 | Force the external interrupt enable to zero |
| illegalEeWr | output | 1 | Illegal enable write seen in debug mode |
| bpWpOut | output | BPWP_W | Breakpoint/watchpoint requests after gating |
| causeReg | output | CAUSE_W | Exception cause register contents |
| savedPc | output | PC_W | Captured program counter |
| savedMsr | output | MSR_W | Captured machine state |

## Verification
There are three kinds of timing to check:
- bpWpOut and the entry strobes are combinational on the current state, so they are due in the same cycle as the cause.
- causeReg, illegalEeWr, the captured values and the mode flags are due one cycle after their stimulus.
- A freeze caused by an event is due two cycles after the event, because the event first has to land in causeReg.

The driver records every expectation with the cycle in which it falls due. The monitor compares expectations only at the falling edge of that exact cycle, so an early or late response counts as a failure.

// File: rtl/dbgctl_pkg.sv
package dbgctl_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // entry decided: capture PC/MSR
    logic clrCause;  // cause register read: clear bits
  } ctlStrobes_t;
endpackage

// File: rtl/dbgctl_datapath.sv
module dbgctl_datapath
  import dbgctl_pkg::*;
#(
  parameter int CAUSE_W = 32,
  parameter int PC_W    = 32,
  parameter int MSR_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobes_t        ctl,
  input  logic [CAUSE_W-1:0] causeEvt,
  input  logic [CAUSE_W-1:0] dbgEnable,
  input  logic [PC_W-1:0]    curPc,
  input  logic [MSR_W-1:0]   curMsr,
  output logic [CAUSE_W-1:0] causeReg,
  output logic               anyCause,
  output logic               pending,
  output logic [PC_W-1:0]    savedPc,
  output logic [MSR_W-1:0]   savedMsr
);
  logic [CAUSE_W-1:0] causeQ;

  // one sticky bit per source; a new event wins over the read clear
  for (genvar b = 0; b < CAUSE_W; b++) begin : gCause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            causeQ[b] <= 1'b0;
      else if (causeEvt[b]) causeQ[b] <= 1'b1;
      else if (ctl.clrCause) causeQ[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedPc  <= '0;
      savedMsr <= '0;
    end else if (ctl.capture) begin
      savedPc  <= curPc;
      savedMsr <= curMsr;
    end
  end

  assign causeReg = causeQ;
  assign anyCause = |causeQ;
  assign pending  = |(causeQ & dbgEnable);
endmodule

// File: rtl/dbgctl_control.sv
module dbgctl_control
  import dbgctl_pkg::*;
#(
  parameter int BPWP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pending,
  input  logic              anyCause,
  input  logic              rfiStrobe,
  input  logic              causeRdStrobe,
  input  logic              eeSetReq,
  input  logic [BPWP_W-1:0] bpWpReq,
  output ctlStrobes_t       ctl,
  output logic              debugMode,
  output logic              freeze,
  output logic              ecrOr,
  output logic              eeClear,
  output logic              illegalEeWr,
  output logic [BPWP_W-1:0] bpWpOut
);
  logic inDbg, frzQ, illegalQ;
  logic enterReq, exitReq, dbgNext;

  assign enterReq = pending && !inDbg;
  assign exitReq  = inDbg && rfiStrobe;

  always_comb begin
    dbgNext = inDbg;
    if (exitReq)       dbgNext = 1'b0;
    else if (enterReq) dbgNext = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inDbg    <= 1'b0;
      frzQ     <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      inDbg    <= dbgNext;
      frzQ     <= dbgNext;
      illegalQ <= inDbg && eeSetReq;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = enterReq;
    ctl.clrCause = causeRdStrobe;
  end

  assign debugMode   = inDbg;
  assign freeze      = frzQ;
  assign eeClear     = enterReq;
  assign ecrOr       = inDbg && anyCause;
  assign illegalEeWr = illegalQ;
  assign bpWpOut     = inDbg ? '0 : bpWpReq;
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbgctl_pkg::*;
#(
  parameter int CAUSE_W = 32,
  parameter int PC_W    = 32,
  parameter int MSR_W   = 32,
  parameter int BPWP_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [CAUSE_W-1:0] causeEvt,
  input  logic [CAUSE_W-1:0] dbgEnable,
  input  logic               rfiStrobe,
  input  logic               causeRdStrobe,
  input  logic               eeSetReq,
  input  logic [BPWP_W-1:0]  bpWpReq,
  input  logic [PC_W-1:0]    curPc,
  input  logic [MSR_W-1:0]   curMsr,
  output logic               freeze,
  output logic               debugMode,
  output logic               ecrOr,
  output logic               saveSrr0,
  output logic               saveSrr1,
  output logic               eeClear,
  output logic               illegalEeWr,
  output logic [BPWP_W-1:0]  bpWpOut,
  output logic [CAUSE_W-1:0] causeReg,
  output logic [PC_W-1:0]    savedPc,
  output logic [MSR_W-1:0]   savedMsr
);
  ctlStrobes_t ctl;
  logic pending, anyCause;

  dbgctl_datapath #(.CAUSE_W(CAUSE_W), .PC_W(PC_W), .MSR_W(MSR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .causeEvt(causeEvt),
    .dbgEnable(dbgEnable), .curPc(curPc), .curMsr(curMsr),
    .causeReg(causeReg), .anyCause(anyCause), .pending(pending),
    .savedPc(savedPc), .savedMsr(savedMsr)
  );

  dbgctl_control #(.BPWP_W(BPWP_W)) uCtl (
    .clk(clk), .rstN(rstN), .pending(pending), .anyCause(anyCause),
    .rfiStrobe(rfiStrobe), .causeRdStrobe(causeRdStrobe),
    .eeSetReq(eeSetReq), .bpWpReq(bpWpReq), .ctl(ctl),
    .debugMode(debugMode), .freeze(freeze), .ecrOr(ecrOr),
    .eeClear(eeClear), .illegalEeWr(illegalEeWr), .bpWpOut(bpWpOut)
  );

  assign saveSrr0 = ctl.capture;
  assign saveSrr1 = ctl.capture;
endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk #(
  parameter int CAUSE_W = 32,
  parameter int PC_W    = 32,
  parameter int MSR_W   = 32,
  parameter int BPWP_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [CAUSE_W-1:0] causeEvt,
  input logic               rfiStrobe,
  input logic               causeRdStrobe,
  input logic               eeSetReq,
  input logic               freeze,
  input logic               debugMode,
  input logic               ecrOr,
  input logic               saveSrr0,
  input logic               saveSrr1,
  input logic               eeClear,
  input logic               illegalEeWr,
  input logic [BPWP_W-1:0]  bpWpOut,
  input logic [CAUSE_W-1:0] causeReg,
  input logic [PC_W-1:0]    savedPc,
  input logic [MSR_W-1:0]   savedMsr
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|causeEvt) |=> ((causeReg & $past(causeEvt)) == $past(causeEvt)));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rstN)
    causeRdStrobe |=> ((causeReg & ~$past(causeEvt)) == '0));

  assert_freeze_after_save_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(freeze) |-> $past(saveSrr0));

  assert_ee_clear_on_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    saveSrr0 |-> eeClear);

  assert_no_save_in_dbg_R6: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |-> !saveSrr1);

  assert_saved_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (debugMode && $past(debugMode)) |-> ($stable(savedPc) && $stable(savedMsr)));

  assert_ecror_low_outside_R7: assert property (@(posedge clk) disable iff (!rstN)
    !debugMode |-> !ecrOr);

  assert_bpwp_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    debugMode |-> (bpWpOut == '0));

  assert_illegal_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (debugMode && eeSetReq) |=> illegalEeWr);

  assert_rfi_exit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (debugMode && rfiStrobe) |=> !freeze);

  assert_rfi_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!debugMode && rfiStrobe && !saveSrr0) |=> !freeze);
endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk #(
  .CAUSE_W(CAUSE_W), .PC_W(PC_W), .MSR_W(MSR_W), .BPWP_W(BPWP_W)
) uChk (
  .clk(clk), .rstN(rstN), .causeEvt(causeEvt), .rfiStrobe(rfiStrobe),
  .causeRdStrobe(causeRdStrobe), .eeSetReq(eeSetReq), .freeze(freeze),
  .debugMode(debugMode), .ecrOr(ecrOr), .saveSrr0(saveSrr0),
  .saveSrr1(saveSrr1), .eeClear(eeClear), .illegalEeWr(illegalEeWr),
  .bpWpOut(bpWpOut), .causeReg(causeReg), .savedPc(savedPc),
  .savedMsr(savedMsr)
);

// File: tb/sim_dbg_mode_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_mode_ctrl;
  localparam int CW = 32;
  localparam int BW = 4;

  localparam int F_FREEZE = 0, F_DBG = 1, F_ECROR = 2, F_SAVE = 3, F_EECLR = 4,
                 F_ILL = 5, F_BPWP = 6, F_CAUSE = 7, F_SPC = 8, F_SMSR = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] causeEvt = '0, dbgEnable = '0;
  logic rfiStrobe = 1'b0, causeRdStrobe = 1'b0, eeSetReq = 1'b0;
  logic [BW-1:0] bpWpReq = '0;
  logic [31:0] curPc = '0, curMsr = '0;
  logic freeze, debugMode, ecrOr, saveSrr0, saveSrr1, eeClear, illegalEeWr;
  logic [BW-1:0] bpWpOut;
  logic [CW-1:0] causeReg;
  logic [31:0] savedPc, savedMsr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    int          fld;
    logic [31:0] val;
    string       req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dbg_mode_ctrl u0 (
    .clk(clk), .rstN(rstN), .causeEvt(causeEvt), .dbgEnable(dbgEnable),
    .rfiStrobe(rfiStrobe), .causeRdStrobe(causeRdStrobe), .eeSetReq(eeSetReq),
    .bpWpReq(bpWpReq), .curPc(curPc), .curMsr(curMsr), .freeze(freeze),
    .debugMode(debugMode), .ecrOr(ecrOr), .saveSrr0(saveSrr0), .saveSrr1(saveSrr1),
    .eeClear(eeClear), .illegalEeWr(illegalEeWr), .bpWpOut(bpWpOut),
    .causeReg(causeReg), .savedPc(savedPc), .savedMsr(savedMsr)
  );

  function automatic logic [31:0] fieldVal(int f);
    case (f)
      F_FREEZE: return {31'd0, freeze};
      F_DBG:    return {31'd0, debugMode};
      F_ECROR:  return {31'd0, ecrOr};
      F_SAVE:   return {31'd0, saveSrr0 & saveSrr1};
      F_EECLR:  return {31'd0, eeClear};
      F_ILL:    return {31'd0, illegalEeWr};
      F_BPWP:   return {28'd0, bpWpOut};
      F_CAUSE:  return causeReg;
      F_SPC:    return savedPc;
      default:  return savedMsr;
    endcase
  endfunction

  task automatic compare(int f, logic [31:0] exp, string req);
    logic [31:0] act;
    act = fieldVal(f);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s field=%0d cycle=%0d actual=%h expected=%h", req, f, cyc, act, exp);
    end
  endtask

  task automatic expect_at(int off, int f, logic [31:0] v, string req);
    item_t it;
    it.due = cyc + off; it.fld = f; it.val = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        compare(sb[i].fld, sb[i].val, sb[i].req);
        sb.delete(i);
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    dbgEnable = 32'h0000_0010;
    curPc = 32'h1000; curMsr = 32'h8000;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    compare(F_FREEZE, 0, "R1"); compare(F_DBG, 0, "R1");
    compare(F_ECROR, 0, "R1"); compare(F_ILL, 0, "R1"); compare(F_CAUSE, 0, "R1");
    tick();

    // outside debug: non-enabled cause, bp passthrough, legal ee set
    causeEvt = 32'h4; bpWpReq = 4'hA; eeSetReq = 1'b1;
    expect_at(1, F_CAUSE, 32'h4, "R2");
    expect_at(2, F_FREEZE, 0, "R3");
    expect_at(2, F_CAUSE, 32'h4, "R2");
    expect_at(0, F_BPWP, 32'hA, "R8");
    expect_at(1, F_ILL, 0, "R9");
    expect_at(1, F_ECROR, 0, "R7");
    tick();
    causeEvt = '0; bpWpReq = '0; eeSetReq = 1'b0;
    tick();
    causeRdStrobe = 1'b1;
    expect_at(1, F_CAUSE, 0, "R4");
    tick();
    causeRdStrobe = 1'b0;
    tick();

    // entry on enabled cause
    causeEvt = 32'h10;
    expect_at(1, F_SAVE, 1, "R5");
    expect_at(1, F_EECLR, 1, "R5");
    expect_at(1, F_FREEZE, 0, "R3");
    expect_at(2, F_FREEZE, 1, "R3");
    expect_at(2, F_DBG, 1, "R3");
    expect_at(2, F_SPC, 32'h1004, "R5");
    expect_at(2, F_SMSR, 32'h9000, "R5");
    expect_at(2, F_ECROR, 1, "R7");
    expect_at(2, F_SAVE, 0, "R5");
    tick();
    causeEvt = '0; curPc = 32'h1004; curMsr = 32'h9000;
    tick();
    curPc = 32'h2000;
    tick();

    // in debug: exception only recorded, bp gated, illegal ee set
    causeEvt = 32'h80; curPc = 32'h3000; curMsr = 32'h1;
    bpWpReq = 4'hF; eeSetReq = 1'b1;
    expect_at(1, F_CAUSE, 32'h90, "R2");
    expect_at(1, F_SAVE, 0, "R6");
    expect_at(2, F_SPC, 32'h1004, "R6");
    expect_at(2, F_SMSR, 32'h9000, "R6");
    expect_at(0, F_BPWP, 0, "R8");
    expect_at(1, F_ILL, 1, "R9");
    expect_at(2, F_ILL, 0, "R9");
    tick();
    causeEvt = '0; bpWpReq = '0; eeSetReq = 1'b0;
    tick();

    // rfi with enabled cause pending: immediate re-entry
    rfiStrobe = 1'b1; curPc = 32'h4000;
    expect_at(1, F_FREEZE, 0, "R10");
    expect_at(1, F_DBG, 0, "R10");
    expect_at(1, F_SAVE, 1, "R11");
    expect_at(2, F_FREEZE, 1, "R11");
    expect_at(2, F_SPC, 32'h5000, "R11");
    tick();
    rfiStrobe = 1'b0; curPc = 32'h5000;
    tick();
    tick();

    // read and event in the same cycle
    causeRdStrobe = 1'b1; causeEvt = 32'h200;
    expect_at(1, F_CAUSE, 32'h200, "R4");
    expect_at(1, F_ECROR, 1, "R7");
    tick();
    causeRdStrobe = 1'b0; causeEvt = '0;
    tick();

    // rfi with nothing enabled pending: stays out
    rfiStrobe = 1'b1;
    expect_at(1, F_DBG, 0, "R10");
    expect_at(1, F_FREEZE, 0, "R10");
    expect_at(1, F_ECROR, 0, "R7");
    expect_at(1, F_SAVE, 0, "R10");
    expect_at(2, F_FREEZE, 0, "R10");
    tick();
    rfiStrobe = 1'b0;
    tick();
    tick();

    // rfi outside debug ignored
    rfiStrobe = 1'b1;
    expect_at(1, F_FREEZE, 0, "R12");
    expect_at(1, F_DBG, 0, "R12");
    expect_at(2, F_FREEZE, 0, "R12");
    tick();
    rfiStrobe = 1'b0;
    repeat (4) tick();

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule